// File: doc/BRIEF.md
# Domain and Access Permission Checker

This block decides whether a memory access that has already found its translation in the TLB may go ahead. It receives the hit entry's mapping kind, permission bits and domain number, along with the virtual address, the access direction, the privilege of the requester, two protection control bits (system and ROM) and the 32-bit domain access control word. The result is a fault code, plus the domain number, which is passed on so that a fault status register can log it.

The check has two stages. First, the entry's domain selects a 2-bit access class from the control word. A "no access" or reserved class stops the access with a domain fault. A manager class lets the access through without checking anything else. A client class moves on to the second stage. That stage picks one of four 2-bit access-permission (AP) fields from the entry, using the mapping kind and some address bits, and judges the access against the rule for that AP value. The whole block is combinational, so the result is valid in the same cycle as the inputs.

Top module: `mmu_perm_check`

## Requirements
- R1: The access class for an entry comes from bits `dacr[2*d+1 : 2*d]`, where d is `dom_idx`. No other bits of `dacr` affect the result.
- R2: Access class 0 (no access) or class 2 (reserved) produces fault code 1 (section domain fault), whatever the permissions are.
- R3: Access class 3 (manager) produces fault code 0 (none) for every AP value, direction and privilege.
- R4: Access class 1 (client) produces fault code 0 when the selected AP field allows the access.
- R5: The AP field index depends on the mapping kind. For small pages (`map_kind`=1) it is `vaddr[11:10]`. For large pages (2) it is `vaddr[15:14]`. For sections (3) it is fixed at 3. For extended small pages (4) and tiny pages (5) it is fixed at 0. Any other code uses index 0.
- R6: The AP field with index i is `perm_bits[2*i+5 : 2*i+4]`.
- R7: AP=0 allows a read only when (`sys_prot`=1 and `is_priv`=1) or `rom_prot`=1. It never allows a write.
- R8: AP=1 allows any privileged access and no unprivileged access.
- R9: AP=2 allows every read, and allows writes only when privileged.
- R10: AP=3 allows every access.
- R11: A client access that the AP field refuses produces fault code 2 (section permission) when `map_kind` is 3, and fault code 3 (subpage permission) for any other mapping kind.
- R12: `fault_dom` always equals `dom_idx`, whether or not there is a fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| map_kind | input | 3 | Mapping kind of the hit entry (0 none, 1 small, 2 large, 3 section, 4 extended small, 5 tiny) |
| perm_bits | input | 12 | Entry permission bits; four AP fields occupy bits 11:4 |
| dom_idx | input | 4 | Domain number of the entry |
| vaddr | input | 32 | Virtual address of the access |
| is_read | input | 1 | 1 for a read, 0 for a write |
| is_priv | input | 1 | 1 when the requester is privileged |
| sys_prot | input | 1 | System protection control bit |
| rom_prot | input | 1 | ROM protection control bit |
| dacr | input | 32 | Domain access control word, 2 bits per domain |
| fault | output | 3 | Fault code: 0 none, 1 section domain, 2 section permission, 3 subpage permission |
| fault_dom | output | 4 | Domain number to record alongside the fault |

## Verification
The bench gives every AP field of an entry a different value and then moves the address bits. A design that took the subpage index from the wrong address bits, or that shifted the AP field by one position, would pass the wrong field and give the wrong allow/deny result. Domains next to each other get opposite access classes, so selecting the wrong 2-bit slice of the control word shows up as a domain fault where none is expected, or the reverse. A sweep covers every AP value against all combinations of direction, privilege, system bit and ROM bit, for every mapping kind. This catches an AP=0 rule that lets writes through or ignores the ROM bit, and a section failure reported with the subpage fault code.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

  typedef enum logic [2:0] {
    MAP_NONE    = 3'd0,
    MAP_SMALL   = 3'd1,
    MAP_LARGE   = 3'd2,
    MAP_SECTION = 3'd3,
    MAP_XSMALL  = 3'd4,
    MAP_TINY    = 3'd5
  } map_kind_e;

  typedef enum logic [2:0] {
    FLT_NONE       = 3'd0,
    FLT_SEC_DOMAIN = 3'd1,
    FLT_SEC_PERM   = 3'd2,
    FLT_SUB_PERM   = 3'd3
  } fault_e;

  typedef enum logic [1:0] {
    DOM_NOACC   = 2'd0,
    DOM_CLIENT  = 2'd1,
    DOM_RSVD    = 2'd2,
    DOM_MANAGER = 2'd3
  } dom_acc_e;

  localparam int unsigned AP_W      = 2;
  localparam int unsigned AP_FIELDS = 4;
  localparam int unsigned AP_BASE   = 4;

endpackage

// File: rtl/mmu_dom_select.sv
module mmu_dom_select
  import mmu_perm_pkg::*;
#(
  parameter int unsigned DOM_W  = 4,
  parameter int unsigned DACR_W = 32
) (
  input  logic [DOM_W-1:0]  dom_idx,
  input  logic [DACR_W-1:0] dacr,
  output dom_acc_e          acc
);
  localparam int unsigned NDOM = 1 << DOM_W;

  logic [1:0] field [NDOM];

  for (genvar d = 0; d < NDOM; d++) begin : g_field
    assign field[d] = dacr[2*d +: 2];
  end

  always_comb begin
    acc = dom_acc_e'(field[dom_idx]);
  end
endmodule

// File: rtl/mmu_ap_select.sv
module mmu_ap_select
  import mmu_perm_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PERM_W = 12
) (
  input  logic [2:0]        map_kind,
  input  logic [PERM_W-1:0] perm_bits,
  input  logic [VA_W-1:0]   vaddr,
  output logic [1:0]        sub_idx,
  output logic [AP_W-1:0]   ap
);
  localparam int unsigned SMALL_LSB = 10;
  localparam int unsigned LARGE_LSB = 14;

  logic [AP_W-1:0] ap_field [AP_FIELDS];

  for (genvar i = 0; i < AP_FIELDS; i++) begin : g_ap
    assign ap_field[i] = perm_bits[AP_BASE + AP_W*i +: AP_W];
  end

  logic unused_va;
  logic unused_perm;
  assign unused_va   = ^{vaddr[VA_W-1:LARGE_LSB+2], vaddr[LARGE_LSB-1:SMALL_LSB+2],
                         vaddr[SMALL_LSB-1:0]};
  assign unused_perm = ^perm_bits[AP_BASE-1:0];

  always_comb begin
    unique case (map_kind)
      MAP_SMALL:   sub_idx = vaddr[SMALL_LSB +: 2];
      MAP_LARGE:   sub_idx = vaddr[LARGE_LSB +: 2];
      MAP_SECTION: sub_idx = 2'd3;
      default:     sub_idx = 2'd0;
    endcase
    ap = ap_field[sub_idx];
  end
endmodule

// File: rtl/mmu_ap_eval.sv
module mmu_ap_eval
  import mmu_perm_pkg::*;
(
  input  logic [AP_W-1:0] ap,
  input  logic            is_read,
  input  logic            is_priv,
  input  logic            sys_prot,
  input  logic            rom_prot,
  output logic            allow
);
  always_comb begin
    unique case (ap)
      2'd0:    allow = is_read && ((sys_prot && is_priv) || rom_prot);
      2'd1:    allow = is_priv;
      2'd2:    allow = is_read || is_priv;
      default: allow = 1'b1;
    endcase
  end
endmodule

// File: rtl/mmu_perm_check.sv
module mmu_perm_check
  import mmu_perm_pkg::*;
#(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PERM_W = 12,
  parameter int unsigned DOM_W  = 4,
  parameter int unsigned DACR_W = 2 * (1 << DOM_W)
) (
  input  logic [2:0]        map_kind,
  input  logic [PERM_W-1:0] perm_bits,
  input  logic [DOM_W-1:0]  dom_idx,
  input  logic [VA_W-1:0]   vaddr,
  input  logic              is_read,
  input  logic              is_priv,
  input  logic              sys_prot,
  input  logic              rom_prot,
  input  logic [DACR_W-1:0] dacr,
  output logic [2:0]        fault,
  output logic [DOM_W-1:0]  fault_dom
);
  dom_acc_e        acc;
  logic [1:0]      sub_idx;
  logic [AP_W-1:0] ap;
  logic            allow;

  mmu_dom_select #(.DOM_W(DOM_W), .DACR_W(DACR_W)) u_dom (
    .dom_idx (dom_idx),
    .dacr    (dacr),
    .acc     (acc)
  );

  mmu_ap_select #(.VA_W(VA_W), .PERM_W(PERM_W)) u_sel (
    .map_kind  (map_kind),
    .perm_bits (perm_bits),
    .vaddr     (vaddr),
    .sub_idx   (sub_idx),
    .ap        (ap)
  );

  mmu_ap_eval u_eval (
    .ap       (ap),
    .is_read  (is_read),
    .is_priv  (is_priv),
    .sys_prot (sys_prot),
    .rom_prot (rom_prot),
    .allow    (allow)
  );

  logic unused_sub;
  assign unused_sub = ^sub_idx;

  always_comb begin
    fault = FLT_NONE;
    unique case (acc)
      DOM_NOACC, DOM_RSVD: fault = FLT_SEC_DOMAIN;
      DOM_CLIENT: begin
        if (!allow) fault = (map_kind == MAP_SECTION) ? FLT_SEC_PERM : FLT_SUB_PERM;
      end
      default: fault = FLT_NONE;
    endcase
  end

  assign fault_dom = dom_idx;

  always_comb begin
    assert_domain_block_R2: assert (!((acc == DOM_NOACC) || (acc == DOM_RSVD)) ||
                                    (fault == FLT_SEC_DOMAIN))
      else $error("domain class did not block access");
    assert_manager_pass_R3: assert (!(acc == DOM_MANAGER) || (fault == FLT_NONE))
      else $error("manager domain raised a fault");
    assert_full_ap_R10: assert (!((acc == DOM_CLIENT) && (ap == 2'd3)) || (fault == FLT_NONE))
      else $error("AP=3 refused an access");
    assert_ap0_write_R7: assert (!((acc == DOM_CLIENT) && (ap == 2'd0) && !is_read) ||
                                 (fault != FLT_NONE))
      else $error("AP=0 allowed a write");
    assert_perm_kind_R11: assert (!(fault == FLT_SEC_PERM) || (map_kind == MAP_SECTION))
      else $error("section permission code on non-section");
    assert_sub_kind_R11: assert (!(fault == FLT_SUB_PERM) || (map_kind != MAP_SECTION))
      else $error("subpage permission code on section");
  end
endmodule

// File: tb/mmu_perm_check_test.sv
module mmu_perm_check_test;

  logic        clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  map_kind;
  logic [11:0] perm_bits;
  logic [3:0]  dom_idx;
  logic [31:0] vaddr;
  logic        is_read, is_priv, sys_prot, rom_prot;
  logic [31:0] dacr;
  logic [2:0]  fault;
  logic [3:0]  fault_dom;

  mmu_perm_check uut (
    .map_kind (map_kind), .perm_bits (perm_bits), .dom_idx (dom_idx),
    .vaddr (vaddr), .is_read (is_read), .is_priv (is_priv),
    .sys_prot (sys_prot), .rom_prot (rom_prot), .dacr (dacr),
    .fault (fault), .fault_dom (fault_dom)
  );

  typedef struct {
    logic [2:0] f;
    logic [3:0] d;
    string      tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // Reference model built from the requirements
  function automatic logic [2:0] model(logic [2:0] mk, logic [11:0] pb, logic [3:0] di,
                                       logic [31:0] va, logic rd, logic pv, logic s,
                                       logic r, logic [31:0] dc);
    logic [1:0] acc, sp, a;
    logic ok;
    acc = dc[di*2 +: 2];                       // R1
    if (acc == 2'd0 || acc == 2'd2) return 3'd1; // R2
    if (acc == 2'd3) return 3'd0;              // R3
    case (mk)                                  // R5
      3'd1: sp = va[11:10];
      3'd2: sp = va[15:14];
      3'd3: sp = 2'd3;
      default: sp = 2'd0;
    endcase
    a = pb[sp*2+4 +: 2];                       // R6
    case (a)
      2'd0: ok = rd && ((s && pv) || r);       // R7
      2'd1: ok = pv;                           // R8
      2'd2: ok = rd || pv;                     // R9
      default: ok = 1'b1;                      // R10
    endcase
    if (ok) return 3'd0;                       // R4
    return (mk == 3'd3) ? 3'd2 : 3'd3;         // R11
  endfunction

  task automatic drive(logic [2:0] mk, logic [11:0] pb, logic [3:0] di, logic [31:0] va,
                       logic rd, logic pv, logic s, logic r, logic [31:0] dc, string tag);
    item_t it;
    @(posedge clk);
    #1;
    map_kind = mk; perm_bits = pb; dom_idx = di; vaddr = va;
    is_read = rd; is_priv = pv; sys_prot = s; rom_prot = r; dacr = dc;
    it.f = model(mk, pb, di, va, rd, pv, s, r, dc);
    it.d = di; // R12
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare away from the edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total++;
      if (fault !== it.f) begin
        bad++;
        $display("FAIL %s fault actual=%0d expected=%0d", it.tag, fault, it.f);
      end
      total++;
      if (fault_dom !== it.d) begin
        bad++;
        $display("FAIL R12 fault_dom actual=%0d expected=%0d", fault_dom, it.d);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [31:0] ALL_CLIENT = 32'h5555_5555;
  localparam logic [11:0] MIX_AP     = 12'b11_10_01_00_0000; // field i holds AP=i

  initial begin
    map_kind = 0; perm_bits = 0; dom_idx = 0; vaddr = 0;
    is_read = 0; is_priv = 0; sys_prot = 0; rom_prot = 0; dacr = 0;

    // Quiet inputs: class 0 on domain 0 gives the domain fault (R2, R12)
    drive(3'd0, 12'h000, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, "R2 idle");

    // R1: domain 7 manager, neighbours no-access / reserved
    drive(3'd1, 12'h000, 4'd7, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_C000, "R1 dom7 mgr");
    drive(3'd1, 12'h000, 4'd6, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_C000, "R1 dom6 none");
    drive(3'd1, 12'hFF0, 4'd8, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0002_C000, "R1 dom8 rsvd");
    drive(3'd1, 12'hFF0, 4'd15, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 32'h4000_0000, "R1 dom15 client");
    // R2: reserved class with full permissions still faults
    drive(3'd3, 12'hFF0, 4'd2, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0020, "R2 reserved");
    // R3: manager ignores AP=0 write
    drive(3'd1, 12'h000, 4'd3, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_00C0, "R3 manager");
    // R4: client allowed
    drive(3'd3, 12'hC00, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R4 client ok");

    // R5/R6: small page, index from vaddr[11:10], unprivileged write
    for (int k = 0; k < 4; k++)
      drive(3'd1, MIX_AP, 4'd1, 32'(k) << 10, 1'b0, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R5 small");
    // large page, index from vaddr[15:14]; bits 11:10 held opposite
    for (int k = 0; k < 4; k++)
      drive(3'd2, MIX_AP, 4'd1, (32'(k) << 14) | (32'(3-k) << 10), 1'b0, 1'b0, 1'b0, 1'b0,
            ALL_CLIENT, "R5 large");
    // section uses field 3, tiny/extended use field 0
    drive(3'd3, 12'h3F0, 4'd1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R5 section");
    drive(3'd5, 12'hFC0, 4'd1, 32'hC00, 1'b1, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R5 tiny");
    drive(3'd4, 12'hFC0, 4'd1, 32'hC000, 1'b1, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R5 xsmall");
    drive(3'd5, 12'h030, 4'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R6 tiny");

    // R7 corners
    drive(3'd1, 12'h000, 4'd0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, ALL_CLIENT, "R7 sys priv read");
    drive(3'd1, 12'h000, 4'd0, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0, ALL_CLIENT, "R7 sys user read");
    drive(3'd1, 12'h000, 4'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, ALL_CLIENT, "R7 rom read");
    drive(3'd1, 12'h000, 4'd0, 32'h0, 1'b0, 1'b1, 1'b1, 1'b1, ALL_CLIENT, "R7 write");
    // R8, R9
    drive(3'd1, 12'h550, 4'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R8 user read");
    drive(3'd1, 12'h550, 4'd0, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, ALL_CLIENT, "R8 priv write");
    drive(3'd1, 12'hAA0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R9 user write");
    drive(3'd1, 12'hAA0, 4'd0, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R9 user read");
    // R11: section vs subpage failure codes
    drive(3'd3, 12'h000, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R11 section");
    drive(3'd2, 12'h000, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, ALL_CLIENT, "R11 large");

    // Sweep: every kind, AP value and control combination (R7 R8 R9 R10 R11)
    for (int mk = 1; mk <= 5; mk++)
      for (int a = 0; a < 4; a++)
        for (int c = 0; c < 16; c++)
          drive(3'(mk), {{4{2'(a)}}, 4'h0}, 4'(c), 32'h1234_0000 ^ (32'(c) << 10),
                c[0], c[1], c[2], c[3], ALL_CLIENT, "R10 sweep");

    @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule